// File: doc/BRIEF.md
# Write-Protect Unlock Gate for a Paged Non-Volatile Memory

This block sits between the external memory control pins and the page buffer of a paged non-volatile memory. Protection is always on: a byte can enter the page buffer only after a fixed three-write unlock sequence has been seen. The block watches the write strobes together with their address and data. When the sequence is complete it opens a write-enable qualifier and passes each later write to the page buffer as a one-cycle load pulse. The three command writes themselves store nothing.

A write that arrives without the full sequence before it stores nothing. The block answers it with a one-cycle dummy request, so the programming timer still spends a full write cycle. When the programming timer reports the end of a cycle, the gate locks again. Every page write therefore needs a fresh sequence. Hardware guards sit in front of the sequence logic:
- a lockout counter that ignores all writes for a set number of cycles after reset;
- a strobe filter that drops pulses that are too short;
- a rule that discards any strobe during which output enable is driven low.

The control pins are assumed to be already synchronised to `clk`.

Top module: `wp_unlock_gate`

## Requirements
- R1: While reset is high, and on the first cycle after it, `wr_open`, `byte_load` and `dummy_req` are 0.
- R2: The unlock sequence is three accepted writes in this order: data 0xAA to address 0x5555, then data 0x55 to address 0x2AAA, then data 0xA0 to address 0x5555. Only address bits [14:0] are compared, so bits 15 and 16 are ignored. After the third write `wr_open` reads 1. None of the three command writes raises `byte_load` or `dummy_req`.
- R3: While `wr_open` is 1, every accepted write gives a one-cycle `byte_load` pulse. `load_addr` and `load_data` carry that write's address and data. The pulse is visible in the second cycle after the cycle in which the strobe was released.
- R4: An accepted write while locked that is not the first command raises `dummy_req` for exactly one cycle. It gives no `byte_load`, and `wr_open` stays 0. `byte_load` and `dummy_req` are never high together.
- R5: An accepted write that does not match the expected second or third command raises `dummy_req` and returns the detector to its start. The full three-write sequence is then needed again.
- R6: In the cycle after `prog_busy` falls, `wr_open` is 0 and the sequence must start again.
- R7: A write that completes while `prog_busy` is 1 is ignored. It raises no pulse and leaves the sequence state unchanged.
- R8: A write that completes within `LOCK_CYCLES` cycles after reset is ignored. It raises no pulse and does not advance the sequence.
- R9: A strobe is a period with `ce_n`=0, `we_n`=0 and `oe_n`=1. A strobe lasting fewer than `GLITCH_MIN` cycles is ignored. A strobe of exactly `GLITCH_MIN` cycles is accepted.
- R10: A strobe during which `oe_n` goes low is discarded. `we_n` low while `ce_n` is high is not a strobe. Neither case raises a pulse or changes state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Write address |
| wdata | input | DATA_W | Write data |
| prog_busy | input | 1 | High while the programming timer runs |
| wr_open | output | 1 | Write-enable qualifier to the page buffer |
| byte_load | output | 1 | One-cycle pulse that loads a byte into the page buffer |
| load_addr | output | ADDR_W | Address for `byte_load` |
| load_data | output | DATA_W | Data for `byte_load` |
| dummy_req | output | 1 | One-cycle pulse that starts the timer without storing data |

## Verification
The bench checks the following corner cases:
- **Aliased addresses.** Command writes use addresses with bits 15 and 16 set. A design that compared the full address would never open.
- **Broken sequences.** A partial sequence is followed by a wrong write, and then by what would have been the correct next step. A design that did not reset the detector would open on a broken sequence.
- **Strobe-length boundary.** Strobes one cycle below `GLITCH_MIN` must be dropped and strobes of exactly `GLITCH_MIN` must be accepted. An off-by-one filter either loses real writes or advances on glitches.
- **Busy window, re-lock and lockout.** Writes during `prog_busy`, the re-lock on its falling edge, and writes inside the power-up window must all be shown to have no effect. A wrong design would either store bytes after programming or issue dummy cycles during lockout.

// File: rtl/wp_gate_pkg.sv
package wp_gate_pkg;

  // Sequence detector states
  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_ARM1   = 2'd1,
    ST_ARM2   = 2'd2,
    ST_OPEN   = 2'd3
  } unlock_state_e;

  // Only the low address bits take part in command matching
  localparam int KEY_AW = 15;

  localparam logic [KEY_AW-1:0] KEY_ADDR_HI = 15'h5555;
  localparam logic [KEY_AW-1:0] KEY_ADDR_LO = 15'h2AAA;
  localparam logic [7:0]        KEY_DATA_1  = 8'hAA;
  localparam logic [7:0]        KEY_DATA_2  = 8'h55;
  localparam logic [7:0]        KEY_DATA_3  = 8'hA0;

endpackage

// File: rtl/wpg_pwrup_lock.sv
module wpg_pwrup_lock #(
  parameter int LOCK_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst,
  output logic ready
);

  localparam int CW = (LOCK_CYCLES < 2) ? 1 : $clog2(LOCK_CYCLES + 1);

  logic ready_q;

  generate
    if (LOCK_CYCLES == 0) begin : g_nolock
      always_ff @(posedge clk) begin
        if (rst) ready_q <= 1'b0;
        else     ready_q <= 1'b1;
      end
    end else begin : g_lock
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q   <= '0;
          ready_q <= 1'b0;
        end else if (!ready_q) begin
          cnt_q   <= cnt_q + CW'(1);
          ready_q <= (cnt_q == CW'(LOCK_CYCLES - 1));
        end
      end
    end
  endgenerate

  assign ready = ready_q;

  // Once the lockout has expired it stays expired until the next reset (R8)
  assert_lock_stays_R8: assert property (@(posedge clk) disable iff (rst)
    ready_q |=> ready_q);

endmodule

// File: rtl/wpg_strobe_filter.sv
module wpg_strobe_filter #(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int GLITCH_MIN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              evt,
  output logic [ADDR_W-1:0] evt_addr,
  output logic [DATA_W-1:0] evt_data
);

  localparam int SAT  = (GLITCH_MIN < 1) ? 1 : GLITCH_MIN;
  localparam int CNT_W = (SAT < 2) ? 1 : $clog2(SAT + 1);

  logic              qual;
  logic              long_enough;
  logic [CNT_W-1:0]  cnt_q;
  logic              evt_q;
  logic [ADDR_W-1:0] cap_addr_q;
  logic [DATA_W-1:0] cap_data_q;

  // A write strobe needs chip and write enable low with outputs disabled
  assign qual = !ce_n && !we_n && oe_n;

  generate
    if (GLITCH_MIN <= 1) begin : g_nofilt
      assign long_enough = 1'b1;
    end else begin : g_filt
      assign long_enough = (cnt_q >= CNT_W'(GLITCH_MIN));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      evt_q      <= 1'b0;
      cap_addr_q <= '0;
      cap_data_q <= '0;
    end else begin
      evt_q <= 1'b0;
      if (qual) begin
        if (cnt_q != CNT_W'(SAT)) cnt_q <= cnt_q + CNT_W'(1);
        cap_addr_q <= addr;
        cap_data_q <= wdata;
      end else if (cnt_q != '0) begin
        cnt_q <= '0;
        // output enable dropping during a strobe discards it
        if (oe_n) evt_q <= long_enough;
      end
    end
  end

  assign evt      = evt_q;
  assign evt_addr = cap_addr_q;
  assign evt_data = cap_data_q;

  // An accepted strobe lasted at least the glitch threshold (R9)
  assert_min_width_R9: assert property (@(posedge clk) disable iff (rst)
    evt_q |-> ($past(cnt_q) >= CNT_W'(SAT)));

  // An accepted strobe ended with output enable high (R10)
  assert_oe_inhibit_R10: assert property (@(posedge clk) disable iff (rst)
    evt_q |-> $past(oe_n));

endmodule

// File: rtl/wpg_unlock_fsm.sv
module wpg_unlock_fsm
  import wp_gate_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [DATA_W-1:0] evt_data,
  input  logic              ready,
  input  logic              prog_busy,
  output logic              wr_open,
  output logic              byte_load,
  output logic [ADDR_W-1:0] load_addr,
  output logic [DATA_W-1:0] load_data,
  output logic              dummy_req
);

  unlock_state_e state_q, base_s, nxt_s;
  logic busy_q;
  logic rearm, take, ld, dm;
  logic hit1, hit2, hit3;
  logic wr_open_q, byte_load_q, dummy_q;
  logic [ADDR_W-1:0] load_addr_q;
  logic [DATA_W-1:0] load_data_q;

  assign hit1 = (evt_addr[KEY_AW-1:0] == KEY_ADDR_HI) && (evt_data == DATA_W'(KEY_DATA_1));
  assign hit2 = (evt_addr[KEY_AW-1:0] == KEY_ADDR_LO) && (evt_data == DATA_W'(KEY_DATA_2));
  assign hit3 = (evt_addr[KEY_AW-1:0] == KEY_ADDR_HI) && (evt_data == DATA_W'(KEY_DATA_3));

  // End of a programming cycle restores protection
  assign rearm = busy_q && !prog_busy;
  assign take  = evt && ready && !prog_busy;

  always_comb begin
    base_s = rearm ? ST_LOCKED : state_q;
    nxt_s  = base_s;
    ld     = 1'b0;
    dm     = 1'b0;
    if (take) begin
      unique case (base_s)
        ST_LOCKED: if (hit1) nxt_s = ST_ARM1;
                   else      dm    = 1'b1;
        ST_ARM1:   if (hit2) nxt_s = ST_ARM2;
                   else begin nxt_s = ST_LOCKED; dm = 1'b1; end
        ST_ARM2:   if (hit3) nxt_s = ST_OPEN;
                   else begin nxt_s = ST_LOCKED; dm = 1'b1; end
        ST_OPEN:   ld = 1'b1;
        default:   nxt_s = ST_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_LOCKED;
      busy_q      <= 1'b0;
      wr_open_q   <= 1'b0;
      byte_load_q <= 1'b0;
      dummy_q     <= 1'b0;
      load_addr_q <= '0;
      load_data_q <= '0;
    end else begin
      state_q     <= nxt_s;
      busy_q      <= prog_busy;
      wr_open_q   <= (nxt_s == ST_OPEN);
      byte_load_q <= ld;
      dummy_q     <= dm;
      if (ld) begin
        load_addr_q <= evt_addr;
        load_data_q <= evt_data;
      end
    end
  end

  assign wr_open   = wr_open_q;
  assign byte_load = byte_load_q;
  assign dummy_req = dummy_q;
  assign load_addr = load_addr_q;
  assign load_data = load_data_q;

  // Load and dummy request never coincide (R4)
  assert_one_action_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({byte_load_q, dummy_q}));

  // A byte load only follows a cycle with the gate open (R3)
  assert_load_needs_open_R3: assert property (@(posedge clk) disable iff (rst)
    byte_load_q |-> $past(wr_open_q));

  // Opening the gate is silent: the last command stores nothing (R2)
  assert_cmd_silent_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_open_q) |-> (!byte_load_q && !dummy_q));

  // Writes during a programming cycle have no effect (R7)
  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    (byte_load_q || dummy_q) |-> !$past(prog_busy));

  // Protection is back one cycle after programming finishes (R6)
  assert_rearm_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(prog_busy) |=> !wr_open_q);

endmodule

// File: rtl/wp_unlock_gate.sv
module wp_unlock_gate #(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 8,
  parameter int GLITCH_MIN  = 3,
  parameter int LOCK_CYCLES = 1000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              prog_busy,
  output logic              wr_open,
  output logic              byte_load,
  output logic [ADDR_W-1:0] load_addr,
  output logic [DATA_W-1:0] load_data,
  output logic              dummy_req
);

  logic              evt;
  logic [ADDR_W-1:0] evt_addr;
  logic [DATA_W-1:0] evt_data;
  logic              lock_ready;

  wpg_pwrup_lock #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk   (clk),
    .rst   (rst),
    .ready (lock_ready)
  );

  wpg_strobe_filter #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .GLITCH_MIN (GLITCH_MIN)
  ) u_filt (
    .clk      (clk),
    .rst      (rst),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .addr     (addr),
    .wdata    (wdata),
    .evt      (evt),
    .evt_addr (evt_addr),
    .evt_data (evt_data)
  );

  wpg_unlock_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .evt_addr  (evt_addr),
    .evt_data  (evt_data),
    .ready     (lock_ready),
    .prog_busy (prog_busy),
    .wr_open   (wr_open),
    .byte_load (byte_load),
    .load_addr (load_addr),
    .load_data (load_data),
    .dummy_req (dummy_req)
  );

  // No action of any kind while the power-up lockout runs (R8)
  assert_lockout_R8: assert property (@(posedge clk) disable iff (rst)
    (byte_load || dummy_req) |-> $past(lock_ready));

  // First cycle out of reset is quiet (R1)
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!wr_open && !byte_load && !dummy_req));

endmodule

// File: tb/tb_wp_unlock_gate.sv
module tb_wp_unlock_gate;

  localparam int AW = 17;
  localparam int DW = 8;
  localparam int GMIN = 3;
  localparam int LOCKC = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic prog_busy = 1'b0;
  logic wr_open, byte_load, dummy_req;
  logic [AW-1:0] load_addr;
  logic [DW-1:0] load_data;

  always #2.5 clk = ~clk;

  wp_unlock_gate #(.ADDR_W(AW), .DATA_W(DW), .GLITCH_MIN(GMIN), .LOCK_CYCLES(LOCKC)) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .prog_busy(prog_busy),
    .wr_open(wr_open), .byte_load(byte_load), .load_addr(load_addr),
    .load_data(load_data), .dummy_req(dummy_req)
  );

  int checks = 0, fails = 0;
  int bl_cnt = 0, dm_cnt = 0;
  logic [AW-1:0] mon_a = '0;
  logic [DW-1:0] mon_d = '0;
  int exp_bl = 0, exp_dm = 0, mstate = 0;
  logic [AW-1:0] exp_a = '0;
  logic [DW-1:0] exp_d = '0;
  bit done = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (byte_load) begin bl_cnt++; mon_a = load_addr; mon_d = load_data; end
      if (dummy_req) dm_cnt++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reference: effect of one accepted write on the sequence
  task automatic model(input logic [AW-1:0] a, input logic [DW-1:0] d);
    case (mstate)
      0: if (a[14:0] == 15'h5555 && d == 8'hAA) mstate = 1; else exp_dm++;
      1: if (a[14:0] == 15'h2AAA && d == 8'h55) mstate = 2; else begin mstate = 0; exp_dm++; end
      2: if (a[14:0] == 15'h5555 && d == 8'hA0) mstate = 3; else begin mstate = 0; exp_dm++; end
      default: begin exp_bl++; exp_a = a; exp_d = d; end
    endcase
  endtask

  task automatic strobe(input logic [AW-1:0] a, input logic [DW-1:0] d, input int len);
    @(negedge clk);
    addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    repeat (len) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input int len);
    strobe(a, d, len);
    model(a, d);
  endtask

  task automatic verify(input string tag);
    chk({tag, " byte_load count"}, bl_cnt, exp_bl);
    chk({tag, " dummy_req count"}, dm_cnt, exp_dm);
    chk({tag, " wr_open"}, {31'd0, wr_open}, {31'd0, mstate == 3});
  endtask

  task automatic unlock(input string tag);
    wr(17'h05555, 8'hAA, GMIN);
    wr(17'h02AAA, 8'h55, GMIN);
    wr(17'h05555, 8'hA0, GMIN);
    verify(tag);
  endtask

  task automatic end_prog();
    @(negedge clk) prog_busy = 1'b1;
    repeat (3) @(negedge clk);
    prog_busy = 1'b0;
    repeat (2) @(negedge clk);
    mstate = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0a17));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 reset wr_open/byte_load/dummy_req", {29'd0, wr_open, byte_load, dummy_req}, 32'd0);
    @(negedge clk) rst = 1'b0;
    chk("R1 first cycle after reset", {29'd0, wr_open, byte_load, dummy_req}, 32'd0);

    // R8: writes inside the lockout window do nothing
    strobe(17'h05555, 8'hAA, 4);
    strobe(17'h01234, 8'h77, 4);
    verify("R8 lockout");
    repeat (LOCKC) @(negedge clk);

    // R4: stray write while locked
    wr(17'h00100, 8'h11, 4);
    verify("R4 stray write");

    // R2: aliased high address bits still match
    wr(17'h1D555, 8'hAA, GMIN);
    wr(17'h0AAAA, 8'h55, GMIN);
    chk("R2 no pulses during commands", dm_cnt, exp_dm);
    wr(17'h05555, 8'hA0, GMIN);
    verify("R2 unlock with aliased address");

    // R3: exact timing of a byte load
    @(negedge clk);
    addr = 17'h1_0234; wdata = 8'h5C; ce_n = 1'b0; we_n = 1'b0;
    repeat (GMIN) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    chk("R3 no load one cycle after release", {31'd0, byte_load}, 32'd0);
    @(negedge clk);
    chk("R3 load two cycles after release", {31'd0, byte_load}, 32'd1);
    chk("R3 load_addr", load_addr, 17'h1_0234);
    chk("R3 load_data", load_data, 8'h5C);
    model(17'h1_0234, 8'h5C);
    repeat (3) @(negedge clk);
    verify("R3 timed load");
    wr(17'h1_0235, 8'hE1, GMIN + 2);
    chk("R3 second load addr", mon_a, exp_a);
    chk("R3 second load data", mon_d, exp_d);

    // R7: write during busy is ignored, gate stays open while busy
    @(negedge clk) prog_busy = 1'b1;
    strobe(17'h00300, 8'h99, 4);
    verify("R7 write during busy");
    // R6: falling busy re-locks on the next cycle
    @(negedge clk) prog_busy = 1'b0;
    @(negedge clk);
    chk("R6 wr_open after busy falls", {31'd0, wr_open}, 32'd0);
    mstate = 0;
    wr(17'h00301, 8'h42, GMIN);
    verify("R6 write after relock is dummy");

    // R5: broken sequence restarts
    wr(17'h05555, 8'hAA, GMIN);
    wr(17'h02AAB, 8'h55, GMIN);
    verify("R5 wrong second step");
    wr(17'h02AAA, 8'h55, GMIN);
    verify("R5 late correct step is not accepted");
    wr(17'h05555, 8'hAA, GMIN);
    wr(17'h02AAA, 8'h55, GMIN);
    wr(17'h05555, 8'hA1, GMIN);
    verify("R5 wrong third step");

    // R9: glitch length boundary
    strobe(17'h05555, 8'hAA, GMIN - 1);
    verify("R9 short strobe ignored");
    wr(17'h05555, 8'hAA, GMIN);
    strobe(17'h00000, 8'h00, 1);
    verify("R9 short garbage ignored mid-sequence");
    wr(17'h02AAA, 8'h55, GMIN);
    wr(17'h05555, 8'hA0, GMIN);
    verify("R9 exact-threshold strobes accepted");

    // R10: output enable low aborts; ce high is no strobe
    @(negedge clk);
    addr = 17'h00400; wdata = 8'h3C; ce_n = 1'b0; we_n = 1'b0;
    repeat (4) @(negedge clk);
    oe_n = 1'b0;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    repeat (4) @(negedge clk);
    verify("R10 oe low aborts strobe");
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b0;
    repeat (5) @(negedge clk);
    we_n = 1'b1;
    repeat (4) @(negedge clk);
    verify("R10 ce high no strobe");
    end_prog();
    verify("R6 relock after programming");

    // Random phase
    for (int i = 0; i < 150; i++) begin
      int r;
      logic [AW-1:0] ra;
      logic [DW-1:0] rd;
      int len;
      r = $urandom % 10;
      ra = AW'($urandom);
      rd = DW'($urandom);
      len = GMIN + ($urandom % 4);
      if (r < 4) begin
        case (mstate)
          0: wr({ra[16:15], 15'h5555}, 8'hAA, len);
          1: wr({ra[16:15], 15'h2AAA}, 8'h55, len);
          2: wr({ra[16:15], 15'h5555}, 8'hA0, len);
          default: wr(ra, rd, len);
        endcase
        verify(mstate == 3 ? "R3 random load" : "R2 random command");
        if (mstate == 3 && bl_cnt == exp_bl) chk("R3 random load addr", mon_a, exp_a);
      end else if (r < 7) begin
        wr(ra, rd, len);
        verify("R5 random write");
      end else if (r == 7) begin
        strobe(ra, rd, 1 + ($urandom % (GMIN - 1)));
        verify("R9 random glitch");
      end else if (r == 8) begin
        @(negedge clk) prog_busy = 1'b1;
        strobe(ra, rd, len);
        verify("R7 random busy write");
        @(negedge clk) prog_busy = 1'b0;
        repeat (2) @(negedge clk);
        mstate = 0;
        verify("R6 random relock");
      end else begin
        @(negedge clk);
        addr = ra; wdata = rd; ce_n = 1'b0; we_n = 1'b0;
        repeat (len) @(negedge clk);
        oe_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (4) @(negedge clk);
        verify("R10 random abort");
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule